// File: doc/BRIEF.md
# Burst Bus Target with Dual-Ready Handshake

This block is the responding side of a synchronous, multiplexed address/data bus. It owns a small array of data words that occupy a fixed address window. An initiator opens a transaction by pulling the active-low frame line low for one address cycle. During that cycle it places a byte address on the shared lines and a four-bit command on the command lines. If the command is a memory read or write and the address falls inside the window, the target claims the transaction. It then moves words in either direction, one word on each rising edge where both ready lines are low.

A burst may be any length. The word index moves up by one after each completed transfer. The initiator raises frame in the cycle of its final word. The target adds a programmable number of wait cycles before its first ready. On reads it keeps its data drivers off for one cycle after the address phase, so the shared lines get a turnaround. If a burst would run past the last word of the window, the target raises stop together with ready on that last word, and the transaction ends there. Three-state behaviour is modelled with separate enable outputs: one for the shared data lines and one for the target's control lines.

Top module: `burst_tgt`

## Requirements
- R1: After reset, and whenever no transaction is claimed, devsel_n, trdy_n and stop_n are 1, and ad_oe and ctl_oe are 0.
- R2: An address phase is a cycle in which the target is idle, frame_n is 0, and frame_n was 1 in the cycle before. The transaction is claimed only in three cases together: cmd is 4'b0110 (memory read) or 4'b0111 (memory write); ad_in[1:0] is 2'b00; and ad_in lies in [WIN_BASE, WIN_BASE + 4*WORDS). When claimed, devsel_n is 0 from the cycle after the address phase. Otherwise devsel_n stays 1 and ctl_oe stays 0.
- R3: Data cycles are numbered from 0, starting with the cycle after the address phase. trdy_n first goes to 0 in data cycle W for a write, or in data cycle W+1 for a read, where W is wait_sel sampled in the address phase. It then stays 0 until the transaction ends.
- R4: A word moves only on a rising edge where irdy_n and trdy_n are both 0. On a write, ad_in is stored in the current word. On a read, ad_out carries the current word while trdy_n is 0.
- R5: The starting word is ad_in[IDXW+1:2] of the address phase. The current word rises by one after each transfer, with no limit on burst length other than R8.
- R6: A transfer made while frame_n is 1 is the last one. In the next cycle, devsel_n, trdy_n and stop_n are 1 and ctl_oe is still 1. One cycle later, ctl_oe is 0.
- R7: ad_oe is 1 only during a read's data cycles, and never in data cycle 0.
- R8: While trdy_n is 0 on word WORDS-1, stop_n is 0. The transfer of that word ends the transaction, even if frame_n is still 0, so a burst moves at most WORDS minus its starting word.
- R9: Commands, addresses and write data of transactions that are not claimed leave every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every signal is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low transaction frame from the initiator |
| irdy_n | input | 1 | Active-low initiator ready |
| cmd | input | 4 | Command, valid in the address phase |
| ad_in | input | 32 | Shared address/data lines as seen by the target |
| wait_sel | input | 2 | Wait cycles inserted before the first target ready |
| ad_out | output | 32 | Read data the target drives onto the shared lines |
| ad_oe | output | 1 | Enable for driving ad_out onto the shared lines |
| trdy_n | output | 1 | Active-low target ready |
| stop_n | output | 1 | Active-low stop (disconnect) request |
| devsel_n | output | 1 | Active-low claim of the transaction |
| ctl_oe | output | 1 | Enable for driving trdy_n, stop_n and devsel_n |

## Verification
Two endings can fall on the same edge: the disconnect at the top of the window, and the initiator raising frame for its final word. The sweep starts bursts of one to four words at every word index of the window, with wait counts 0, 1 and 3, plus some bursts with initiator stalls. This makes bursts near the top end exactly on the last word with frame high, and also end by stop alone with frame still low. Each case is judged by the number of words moved, by stop_n and trdy_n on each data cycle, and by the released control lines in the cycle that follows. A full read-back of the window then confirms that nothing was written past its end.

// File: rtl/burst_tgt_pkg.sv
package burst_tgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TURN = 2'd2
  } phase_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  function automatic logic cmd_is_mem(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return c == CMD_MEM_RD;
  endfunction

endpackage

// File: rtl/bt_addr_decode.sv
module bt_addr_decode #(
  parameter int          AW       = 32,
  parameter int          IDXW     = 4,
  parameter logic [31:0] WIN_BASE = 32'h0000_0400
) (
  input  logic [AW-1:0]   addr,
  input  logic [3:0]      cmd,
  output logic            hit,
  output logic            is_read,
  output logic [IDXW-1:0] start_idx
);
  import burst_tgt_pkg::*;

  localparam int TAGW = AW - IDXW - 2;
  localparam logic [TAGW-1:0] WIN_TAG = WIN_BASE[AW-1:IDXW+2];

  function automatic logic in_window(input logic [AW-1:0] a);
    return (a[AW-1:IDXW+2] == WIN_TAG) && (a[1:0] == 2'b00);
  endfunction

  assign hit       = in_window(addr) && cmd_is_mem(cmd);
  assign is_read   = cmd_is_read(cmd);
  assign start_idx = addr[IDXW+1:2];

endmodule

// File: rtl/bt_wait_timer.sv
module bt_wait_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count_in,
  input  logic          extra,
  output logic          ready
);
  logic [CW:0] cnt;

  function automatic logic [CW:0] start_value(input logic [CW-1:0] c, input logic e);
    return {1'b0, c} + {{CW{1'b0}}, e};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= start_value(count_in, extra);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> ready); // R3

endmodule

// File: rtl/bt_word_store.sv
module bt_word_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (words[$past(idx)] == $past(wdata))); // R4

endmodule

// File: rtl/burst_tgt.sv
module burst_tgt #(
  parameter int          DW       = 32,
  parameter int          WORDS    = 16,
  parameter int          WCW      = 2,
  parameter logic [31:0] WIN_BASE = 32'h0000_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [3:0]    cmd,
  input  logic [31:0]   ad_in,
  input  logic [WCW-1:0] wait_sel,
  output logic [31:0]   ad_out,
  output logic          ad_oe,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          devsel_n,
  output logic          ctl_oe
);
  import burst_tgt_pkg::*;

  localparam int IDXW = $clog2(WORDS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WORDS - 1);

  phase_t          phase;
  logic            frame_q;
  logic            rd_q;
  logic            first_q;
  logic [IDXW-1:0] idx;

  logic            dec_hit, dec_rd;
  logic [IDXW-1:0] dec_idx;
  logic            wt_ready;

  // named internal events
  logic addr_phase, claim, tready, xfer, last_word, ending;

  bt_addr_decode #(.AW(32), .IDXW(IDXW), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(ad_in), .cmd(cmd), .hit(dec_hit), .is_read(dec_rd), .start_idx(dec_idx)
  );

  bt_wait_timer #(.CW(WCW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(claim), .count_in(wait_sel),
    .extra(dec_rd), .ready(wt_ready)
  );

  bt_word_store #(.DW(DW), .DEPTH(WORDS), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(xfer && !rd_q), .idx(idx),
    .wdata(ad_in[DW-1:0]), .rdata(ad_out[DW-1:0])
  );

  generate
    if (DW < 32) begin : g_pad
      assign ad_out[31:DW] = '0;
    end
  endgenerate

  assign addr_phase = (phase == PH_IDLE) && !frame_n && frame_q;
  assign claim      = addr_phase && dec_hit;
  assign tready     = (phase == PH_DATA) && wt_ready;
  assign xfer       = tready && !irdy_n;
  assign last_word  = (idx == LAST_IDX);
  assign ending     = xfer && (frame_n || last_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      frame_q <= 1'b1;
      rd_q    <= 1'b0;
      first_q <= 1'b0;
      idx     <= '0;
    end else begin
      frame_q <= frame_n;
      unique case (phase)
        PH_IDLE: if (claim) begin
          phase   <= PH_DATA;
          rd_q    <= dec_rd;
          first_q <= 1'b1;
          idx     <= dec_idx;
        end
        PH_DATA: begin
          first_q <= 1'b0;
          if (xfer)   idx   <= idx + 1'b1;
          if (ending) phase <= PH_TURN;
        end
        PH_TURN: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign devsel_n = (phase != PH_DATA);
  assign trdy_n   = !tready;
  assign stop_n   = !(tready && last_word);
  assign ctl_oe   = (phase != PH_IDLE);
  assign ad_oe    = (phase == PH_DATA) && rd_q && !first_q;

  AST_CLAIM_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n)); // R2
  AST_READY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n); // R4
  AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ending) |=> (idx == $past(idx) + 1'b1)); // R5
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> (devsel_n && trdy_n && stop_n && ctl_oe)); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!devsel_n && $past(!devsel_n))); // R7
  AST_STOP_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !trdy_n); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !irdy_n) |=> devsel_n); // R8

endmodule

// File: tb/burst_tgt_bench.sv
module burst_tgt_bench;
  localparam int          WORDS    = 16;
  localparam logic [31:0] BASE     = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cmd = 4'h0;
  logic [31:0] ad_in = '0;
  logic [1:0]  wait_sel = 2'd0;
  logic [31:0] ad_out;
  logic        ad_oe, trdy_n, stop_n, devsel_n, ctl_oe;

  int total = 0;
  int fails = 0;
  logic [31:0] model [WORDS];
  logic [31:0] seed = 32'h1357_9bdf;

  always #4 clk = ~clk;

  burst_tgt u_burst_tgt (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cmd(cmd),
    .ad_in(ad_in), .wait_sel(wait_sel), .ad_out(ad_out), .ad_oe(ad_oe),
    .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit hits(input logic [3:0] c, input logic [31:0] a);
    return (c == 4'b0110 || c == 4'b0111) && a[1:0] == 2'b00 &&
           a >= BASE && a < BASE + 4 * WORDS;
  endfunction

  task automatic burst(input logic [3:0] c, input logic [31:0] a, input int n,
                       input int w, input bit stall);
    bit hit = hits(c, a);
    bit rd  = (c == 4'b0110);
    int idx = int'(a[5:2]);
    int start = idx;
    int done = 0;
    int k = 0;
    bit fin = 0;
    int lat = w + (rd ? 1 : 0);
    wait_sel = 2'(w);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cmd = c; ad_in = a;
    while (!fin && k < 64) begin
      bit st;
      bit exp_rdy;
      @(negedge clk);
      st = stall && (n - done > 1) && (k % 3 == 1);
      irdy_n  = st;
      frame_n = (!st && (n - done == 1)) ? 1'b1 : 1'b0;
      seed    = seed * 32'd1103515245 + 32'd12345;
      ad_in   = rd ? seed : (seed ^ 32'(idx));
      #1;
      if (!hit) begin
        chk(devsel_n && ctl_oe == 1'b0 && trdy_n, "R2 unclaimed", {devsel_n, ctl_oe, trdy_n}, 3'b101);
        if (k == 3) fin = 1;
      end else begin
        exp_rdy = (k >= lat);
        if (k == 0) chk(devsel_n == 1'b0, "R2 claim", devsel_n, 0);
        chk(trdy_n == !exp_rdy, "R3 ready timing", trdy_n, !exp_rdy);
        chk(ad_oe == (rd && k >= 1), "R7 data enable", ad_oe, rd && k >= 1);
        chk(stop_n == !(exp_rdy && idx == WORDS - 1), "R8 stop", stop_n, !(exp_rdy && idx == WORDS - 1));
        if (!irdy_n && !trdy_n) begin
          if (rd) chk(ad_out == model[idx], "R4 R5 read data", ad_out, model[idx]);
          else model[idx] = ad_in;
          done++;
          if (frame_n || idx == WORDS - 1) fin = 1;
          idx++;
        end
      end
      k++;
    end
    if (hit) begin
      int exp_n = (n < WORDS - start) ? n : WORDS - start;
      chk(done == exp_n, "R5 R8 word count", done, exp_n);
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1;
    #1;
    if (hit) chk(devsel_n && trdy_n && stop_n && ctl_oe, "R6 release", {devsel_n, trdy_n, stop_n, ctl_oe}, 4'hF);
    @(negedge clk);
    #1;
    chk(ctl_oe == 1'b0 && devsel_n && !ad_oe, "R1 R6 idle", {ctl_oe, devsel_n, ad_oe}, 3'b010);
  endtask

  task automatic read_all(input int w);
    burst(4'b0110, BASE, WORDS, w, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(devsel_n && trdy_n && stop_n && !ad_oe && !ctl_oe, "R1 reset",
        {devsel_n, trdy_n, stop_n, ad_oe, ctl_oe}, 5'b11100);
    rst_n = 1'b1;
    read_all(0);
    for (int wi = 0; wi < 3; wi++) begin
      int w = (wi == 2) ? 3 : wi;
      for (int s = 0; s < WORDS; s++) begin
        for (int len = 1; len <= 4; len++) begin
          burst(4'b0111, BASE + 32'(4 * s), len, w, len == 4);
          burst(4'b0110, BASE + 32'(4 * s), len, w, len == 3);
        end
      end
    end
    burst(4'b0111, BASE, 20, 1, 1'b1);
    read_all(3);
    burst(4'b0111, BASE + 32'h28, 30, 0, 1'b0);
    // R9: non-claimed transactions must leave storage untouched
    burst(4'b0111, BASE + 4 * WORDS, 3, 0, 1'b0);
    burst(4'b0111, BASE - 4, 3, 0, 1'b0);
    burst(4'b0011, BASE + 8, 3, 0, 1'b0);
    burst(4'b0111, BASE + 2, 3, 0, 1'b0);
    burst(4'b0010, BASE, 2, 0, 1'b0);
    read_all(1);
    chk(1'b1, "R9 covered by read-back", 0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule